// File: doc/BRIEF.md
# Secure Element Supervisory Controller

This block is a Moore state machine that supervises a cryptographic secure element. It brings the element up after reset and waits for the supply to be stable. It then runs a self-test and parks in a ready state. From there it can open secure-channel sessions or drop into a low-power state. A tamper or attack indication overrides every other condition and locks the controller into an alarm state that only reset can clear. A failed self-test locks it into a fault state.

The controller reports its condition on six status lines, and exactly one of them is high at any time. Each line is a registered Moore decode of the state being entered, so the status changes only at clock edges. The status always matches the state register. The cryptographic work itself happens elsewhere; this block only decides when it is allowed.

Top module: `se_supervisor`

## Requirements
- R1: While reset is low and on the first clock after its release, only `busy_o` is high. Applying reset again from any state returns the outputs to that pattern.
- R2: After reset the controller stays in its boot state (`busy_o` high) until `pwr_good_i` has been sampled high on `BOOT_CYCLES` consecutive rising edges. On that edge it enters self-test, where `busy_o` stays high. A low sample restarts the count. `pwr_good_i` has no effect in any other state.
- R3: In self-test, `st_fail_i` moves the controller to fault (`fault_o`) and wins over `st_pass_i`. `st_pass_i` alone moves it to ready (`ready_o`). With neither input high, the controller stays in self-test.
- R4: The fault state ignores every input except `attack_i` and reset.
- R5: Only the ready state honours `chan_req_i`, which leads to the channel state (`chan_active_o`), and `sleep_req_i`, which leads to low power (`low_power_o`). With the default `CHAN_FIRST`=1 the channel request wins when both are high. These requests have no effect in any other state.
- R6: In the channel state, `chan_done_i` returns the controller to ready. All other inputs except `attack_i` are ignored there.
- R7: In low power, `wake_i` returns the controller to ready. All other inputs except `attack_i` are ignored there.
- R8: `attack_i` sampled high on an edge puts the controller in alarm (`alarm_o`) on that same edge, from any state. The alarm holds until reset whatever the other inputs do, and `chan_active_o` is low throughout it.
- R9: Exactly one of `busy_o`, `ready_o`, `chan_active_o`, `low_power_o`, `alarm_o`, `fault_o` is high in every cycle. Each transition is visible on the status lines right after the edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply stable indication |
| st_pass_i | input | 1 | Self-test passed |
| st_fail_i | input | 1 | Self-test failed |
| chan_req_i | input | 1 | Request to open a secure-channel session |
| chan_done_i | input | 1 | Secure-channel session finished |
| sleep_req_i | input | 1 | Request to enter low power |
| wake_i | input | 1 | Wake from low power |
| attack_i | input | 1 | Attack or tamper detected |
| busy_o | output | 1 | Boot or self-test in progress |
| ready_o | output | 1 | Idle and ready for requests |
| chan_active_o | output | 1 | Secure-channel session enabled |
| low_power_o | output | 1 | Low-power state |
| alarm_o | output | 1 | Attack response, locked until reset |
| fault_o | output | 1 | Self-test failure, locked until reset |

## Verification
Every status result is due exactly one rising edge after the stimulus that causes it, because the status register loads the decode of the next state. The one exception is the boot exit, which is due on the `BOOT_CYCLES`-th consecutive edge with power good high. The bench changes inputs on falling edges and reads the status on the following falling edge, so each sample lands half a period after the single edge that should have acted. The bench reaches each of the seven states and applies all 256 combinations of the eight control inputs, one per visit. It then compares the status word with the next state predicted by a transition table written from the requirements. Directed sequences cover the interrupted boot count and reset from a late state.

// File: rtl/se_sup_pkg.sv
package se_sup_pkg;

   typedef enum logic [2:0] {
      SUP_BOOT     = 3'd0,
      SUP_SELFTEST = 3'd1,
      SUP_IDLE     = 3'd2,
      SUP_CHANNEL  = 3'd3,
      SUP_SLEEP    = 3'd4,
      SUP_ALARM    = 3'd5,
      SUP_FAULT    = 3'd6
   } sup_state_e;

   localparam int unsigned SUP_STATUS_W = 6;

   typedef struct packed {
      logic fault;
      logic alarm;
      logic low_power;
      logic chan_active;
      logic ready;
      logic busy;
   } sup_status_t;

   function automatic sup_status_t sup_decode(input sup_state_e s);
      sup_status_t st;
      st = '0;
      unique case (s)
         SUP_BOOT, SUP_SELFTEST: st.busy        = 1'b1;
         SUP_IDLE:               st.ready       = 1'b1;
         SUP_CHANNEL:            st.chan_active = 1'b1;
         SUP_SLEEP:              st.low_power   = 1'b1;
         SUP_ALARM:              st.alarm       = 1'b1;
         default:                st.fault       = 1'b1;
      endcase
      return st;
   endfunction

endpackage

// File: rtl/se_sup_boot_timer.sv
module se_sup_boot_timer #(
   parameter int unsigned COUNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic pwr_good_i,
   output logic done_o
);
   localparam int unsigned CW = (COUNT < 2) ? 1 : $clog2(COUNT);
   localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (COUNT >= 2) else $error("boot timer: COUNT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || !pwr_good_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = run_i && pwr_good_i && (cnt_q == LAST);

   // R2: the counter never passes its terminal value
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/se_sup_next_state.sv
module se_sup_next_state
   import se_sup_pkg::*;
#(
   parameter bit CHAN_FIRST = 1'b1
) (
   input  sup_state_e state_i,
   input  logic       boot_done_i,
   input  logic       st_pass_i,
   input  logic       st_fail_i,
   input  logic       chan_req_i,
   input  logic       chan_done_i,
   input  logic       sleep_req_i,
   input  logic       wake_i,
   input  logic       attack_i,
   output sup_state_e state_o
);
   sup_state_e idle_next;

   generate
      if (CHAN_FIRST) begin : g_chan_first
         assign idle_next = chan_req_i  ? SUP_CHANNEL :
                            sleep_req_i ? SUP_SLEEP   : SUP_IDLE;
      end else begin : g_sleep_first
         assign idle_next = sleep_req_i ? SUP_SLEEP   :
                            chan_req_i  ? SUP_CHANNEL : SUP_IDLE;
      end
   endgenerate

   always_comb begin
      state_o = state_i;
      if (attack_i) begin
         state_o = SUP_ALARM;
      end else begin
         unique case (state_i)
            SUP_BOOT:     if (boot_done_i) state_o = SUP_SELFTEST;
            SUP_SELFTEST: begin
               if (st_fail_i)      state_o = SUP_FAULT;
               else if (st_pass_i) state_o = SUP_IDLE;
            end
            SUP_IDLE:     state_o = idle_next;
            SUP_CHANNEL:  if (chan_done_i) state_o = SUP_IDLE;
            SUP_SLEEP:    if (wake_i)      state_o = SUP_IDLE;
            SUP_ALARM:    state_o = SUP_ALARM;
            default:      state_o = SUP_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/se_sup_status_reg.sv
module se_sup_status_reg
   import se_sup_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  sup_state_e  state_d_i,
   output sup_status_t status_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o <= sup_decode(SUP_BOOT);
      else        status_o <= sup_decode(state_d_i);
   end
endmodule

// File: rtl/se_supervisor.sv
module se_supervisor
   import se_sup_pkg::*;
#(
   parameter int unsigned BOOT_CYCLES = 16,
   parameter bit          CHAN_FIRST  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good_i,
   input  logic st_pass_i,
   input  logic st_fail_i,
   input  logic chan_req_i,
   input  logic chan_done_i,
   input  logic sleep_req_i,
   input  logic wake_i,
   input  logic attack_i,
   output logic busy_o,
   output logic ready_o,
   output logic chan_active_o,
   output logic low_power_o,
   output logic alarm_o,
   output logic fault_o
);
   sup_state_e  state_q, state_d;
   sup_status_t status_q;
   logic        boot_done;

   initial begin
      assert (BOOT_CYCLES >= 2) else $error("se_supervisor: BOOT_CYCLES must be at least 2");
   end

   se_sup_boot_timer #(.COUNT(BOOT_CYCLES)) u_boot (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (state_q == SUP_BOOT),
      .pwr_good_i(pwr_good_i),
      .done_o    (boot_done)
   );

   se_sup_next_state #(.CHAN_FIRST(CHAN_FIRST)) u_next (
      .state_i    (state_q),
      .boot_done_i(boot_done),
      .st_pass_i  (st_pass_i),
      .st_fail_i  (st_fail_i),
      .chan_req_i (chan_req_i),
      .chan_done_i(chan_done_i),
      .sleep_req_i(sleep_req_i),
      .wake_i     (wake_i),
      .attack_i   (attack_i),
      .state_o    (state_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SUP_BOOT;
      else        state_q <= state_d;
   end

   se_sup_status_reg u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_d_i(state_d),
      .status_o (status_q)
   );

   assign busy_o        = status_q.busy;
   assign ready_o       = status_q.ready;
   assign chan_active_o = status_q.chan_active;
   assign low_power_o   = status_q.low_power;
   assign alarm_o       = status_q.alarm;
   assign fault_o       = status_q.fault;

   p_one_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status_q) == 1);

   p_status_tracks_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status_q == sup_decode(state_q));

   p_attack_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      attack_i |=> alarm_o);

   p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |=> alarm_o);

   p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o && !attack_i |=> fault_o);

   p_fault_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> $past(st_fail_i) && $past(busy_o));

   p_chan_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_active_o) |-> $past(ready_o) && $past(chan_req_i));

   p_sleep_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_power_o) |-> $past(ready_o) && $past(sleep_req_i));

   p_chan_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_active_o && chan_done_i && !attack_i |=> ready_o);

   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      low_power_o && wake_i && !attack_i |=> ready_o);

endmodule

// File: tb/se_supervisor_test.sv
module se_supervisor_test;
   localparam int BOOT_N = 3;

   // bench-side state numbering
   localparam int S_BOOT = 0, S_TEST = 1, S_IDLE = 2, S_CHAN = 3,
                  S_SLEEP = 4, S_ALARM = 5, S_FAULT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pg = 0, pass = 0, fail = 0, req = 0, done = 0, slp = 0, wake = 0, atk = 0;
   logic busy, ready, chan, lowp, alarm, fault;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   se_supervisor #(.BOOT_CYCLES(BOOT_N)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .st_pass_i(pass),
      .st_fail_i(fail), .chan_req_i(req), .chan_done_i(done),
      .sleep_req_i(slp), .wake_i(wake), .attack_i(atk),
      .busy_o(busy), .ready_o(ready), .chan_active_o(chan),
      .low_power_o(lowp), .alarm_o(alarm), .fault_o(fault)
   );

   // {fault, alarm, low_power, chan_active, ready, busy}
   function automatic logic [5:0] exp_status(input int s);
      case (s)
         S_BOOT, S_TEST: return 6'b000001;
         S_IDLE:         return 6'b000010;
         S_CHAN:         return 6'b000100;
         S_SLEEP:        return 6'b001000;
         S_ALARM:        return 6'b010000;
         default:        return 6'b100000;
      endcase
   endfunction

   // vector bits: 0 pg, 1 pass, 2 fail, 3 req, 4 done, 5 sleep, 6 wake, 7 attack
   function automatic int exp_next(input int s, input logic [7:0] v);
      if (v[7]) return S_ALARM;
      case (s)
         S_BOOT:  return S_BOOT;   // count is zero on entry, BOOT_N > 1
         S_TEST:  return v[2] ? S_FAULT : (v[1] ? S_IDLE : S_TEST);
         S_IDLE:  return v[3] ? S_CHAN : (v[5] ? S_SLEEP : S_IDLE);
         S_CHAN:  return v[4] ? S_IDLE : S_CHAN;
         S_SLEEP: return v[6] ? S_IDLE : S_SLEEP;
         default: return s;
      endcase
   endfunction

   function automatic string req_tag(input int s, input logic [7:0] v);
      if (v[7]) return "R8";
      case (s)
         S_BOOT:  return "R2";
         S_TEST:  return "R3";
         S_IDLE:  return "R5";
         S_CHAN:  return "R6";
         S_SLEEP: return "R7";
         S_ALARM: return "R8";
         default: return "R4";
      endcase
   endfunction

   function automatic logic [5:0] act_status();
      return {fault, alarm, lowp, chan, ready, busy};
   endfunction

   task automatic check(input string tag, input logic [5:0] exp);
      logic [5:0] act;
      act = act_status();
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: status actual %b expected %b", tag, act, exp);
      end
      if ($countones(act) != 1) begin
         n_fails++;
         $display("FAIL R9: status actual %b expected one-hot", act);
      end
   endtask

   task automatic apply(input logic [7:0] v);
      {atk, wake, slp, done, req, fail, pass, pg} = v;
      @(negedge clk);
   endtask

   task automatic do_reset();
      {atk, wake, slp, done, req, fail, pass, pg} = '0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic goto_state(input int s);
      do_reset();
      case (s)
         S_TEST:  repeat (BOOT_N) apply(8'h01);
         S_IDLE:  begin repeat (BOOT_N) apply(8'h01); apply(8'h02); end
         S_CHAN:  begin repeat (BOOT_N) apply(8'h01); apply(8'h02); apply(8'h08); end
         S_SLEEP: begin repeat (BOOT_N) apply(8'h01); apply(8'h02); apply(8'h20); end
         S_FAULT: begin repeat (BOOT_N) apply(8'h01); apply(8'h04); end
         S_ALARM: apply(8'h80);
         default: ;
      endcase
      apply(8'h00);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      @(negedge clk);
      // R1: reset pattern, during reset and after release
      check("R1", 6'b000001);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 6'b000001);

      // R2: interrupted power-good count restarts
      do_reset();
      apply(8'h01); apply(8'h01); apply(8'h00);
      apply(8'h01); apply(8'h01);
      check("R2", 6'b000001);
      apply(8'h03);              // third consecutive edge: enters self-test only
      check("R2", 6'b000001);
      apply(8'h02);              // pass now accepted in self-test
      check("R2", 6'b000010);

      // R2: power-good ignored once running
      apply(8'h00);
      check("R2", 6'b000010);

      // R1: reset from a late state
      goto_state(S_CHAN);
      check("R5", 6'b000100);
      do_reset();
      check("R1", 6'b000001);

      // R8: alarm sticky under sustained stimulus, channel disabled
      goto_state(S_CHAN);
      apply(8'h80);
      check("R8", 6'b010000);
      apply(8'h7F);
      check("R8", 6'b010000);
      if (chan !== 1'b0) begin
         n_fails++;
         $display("FAIL R8: chan_active actual %b expected 0", chan);
      end
      n_checks++;

      // R3..R9 sweep: every state, every input combination
      for (int s = 0; s < 7; s++) begin
         for (int v = 0; v < 256; v++) begin
            goto_state(s);
            check("R9", exp_status(s));
            apply(v[7:0]);
            check(req_tag(s, v[7:0]), exp_status(exp_next(s, v[7:0])));
         end
      end

      report();
   end
endmodule